// File: doc/BRIEF.md
# UART Interrupt Enable and Identification Unit

This block sits beside a UART's receive path, receive FIFO and transmit path and turns their raw event conditions into a single interrupt request. The four conditions are a receive line error, receive data at or above the FIFO trigger level, a character timeout and an empty transmit holding register. A small register port lets software program a 3-bit interrupt enable register. The same port returns an identification byte. That byte names the single highest-priority enabled source, together with an active-low pending flag.

The identification value is held in a snapshot register. The snapshot follows the live prioritised result on every clock edge, except on an edge at which the identification register is being read. On that edge it is held, so the value software sees cannot change under it. An event that arises during the read is therefore reported only by the next read. The transmit-empty source is edge-latched, and it is cleared either by a read that reports it or by a write into the transmit holding register. The receive sources follow their input levels.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register (bus_addr = 0) resets to 0x00. A write keeps only bits 2:0, and bits 7:3 always read 0.
- R2: After reset, with fifo_en low, the identification register (bus_addr = 1) reads 0x01 and irq is low.
- R3: An enabled line error (enable bit 2) is reported as code 011 in identification bits 3:1. This code wins over every other source.
- R4: Enable bit 0 gates both the receive-data source (code 010) and the timeout source (code 110). Data available wins over timeout.
- R5: An enabled transmit-empty source (enable bit 1) is reported as code 001, and only when no receive-side source is enabled and active.
- R6: When no enabled source is pending, identification bits 3:0 read 0001. Codes 000, 100, 101 and 111 are never reported with bit 0 low.
- R7: Identification bits 7 and 6 both equal fifo_en, and bits 5:4 read 0.
- R8: irq is high exactly when identification bit 0 reads 0.
- R9: On a clock edge where bus_rd is high with bus_addr = 1, the identification value does not change. An event that first appears in that cycle is seen only by the next read.
- R10: The transmit-empty condition latches on a rising edge of tx_empty. It is cleared by a thr_write pulse, or by an identification read that returns code 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register select: 0 enable, 1 identification |
| bus_wr | input | 1 | Write strobe (enable register only) |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| fifo_en | input | 1 | FIFO enable control, mirrored into identification bits 7:6 |
| thr_write | input | 1 | Pulse: transmit holding register written |
| line_err | input | 1 | Level: receive line error present |
| rx_avail | input | 1 | Level: receive data at or above trigger level |
| rx_timeout | input | 1 | Level: character timeout |
| tx_empty | input | 1 | Level: transmit holding register empty |
| irq | output | 1 | Interrupt request |

## Verification
Two activities can coincide: an identification read, and a change in the source conditions, either a new higher-priority event or the latching of the transmit-empty edge. The bench provokes this by raising a line error in the very cycle it reads the identification register while a data-available source is already pending. The read must return the data-available code, and the value must still show that code one cycle later. Only the following read may report the line error. All sixteen source combinations are also walked with every source enabled, and random enable and source patterns are compared against a priority model written in the bench.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int REG_W   = 8;
    localparam int EN_W    = 3;
    localparam int EN_RX   = 0;
    localparam int EN_TX   = 1;
    localparam int EN_LS   = 2;

    typedef enum logic [2:0] {
        ID_NONE = 3'b000,
        ID_THRE = 3'b001,
        ID_RDA  = 3'b010,
        ID_RLS  = 3'b011,
        ID_CTI  = 3'b110
    } irq_id_e;

    typedef struct packed {
        logic line_err;
        logic rx_avail;
        logic rx_tmo;
        logic tx_empty;
    } irq_src_t;

    typedef struct packed {
        irq_id_e id;
        logic    pend_n;
    } ident_t;

    localparam ident_t IDENT_IDLE = '{id: ID_NONE, pend_n: 1'b1};

    // fixed priority: line status, then data available, timeout, transmit empty
    function automatic ident_t pick_ident(input irq_src_t s, input logic [EN_W-1:0] en);
        ident_t r;
        r = IDENT_IDLE;
        if (en[EN_LS] && s.line_err)
            r = '{id: ID_RLS, pend_n: 1'b0};
        else if (en[EN_RX] && s.rx_avail)
            r = '{id: ID_RDA, pend_n: 1'b0};
        else if (en[EN_RX] && s.rx_tmo)
            r = '{id: ID_CTI, pend_n: 1'b0};
        else if (en[EN_TX] && s.tx_empty)
            r = '{id: ID_THRE, pend_n: 1'b0};
        return r;
    endfunction

    function automatic logic id_is_legal(input logic [2:0] c);
        return (c == ID_THRE) || (c == ID_RDA) || (c == ID_RLS) || (c == ID_CTI);
    endfunction

endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [EN_W-1:0]   en
);
    always_ff @(posedge clk) begin
        if (rst)
            en <= '0;
        else if (wr)
            en <= wdata[EN_W-1:0];
    end

    assert_en_write_R1: assert property (@(posedge clk) disable iff (rst)
        wr |=> en == $past(wdata[EN_W-1:0]));
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
    input  logic clk,
    input  logic rst,
    input  logic tx_empty,
    input  logic thr_write,
    input  logic rd_clear,
    output logic pend,
    output logic rise
);
    logic tx_prev;

    assign rise = tx_empty && !tx_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_prev <= 1'b0;
            pend    <= 1'b0;
        end else begin
            tx_prev <= tx_empty;
            if (rise)
                pend <= 1'b1;
            else if (thr_write || rd_clear)
                pend <= 1'b0;
        end
    end

    assert_thre_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (thr_write && !rise) |=> !pend);
    assert_thre_set_R10: assert property (@(posedge clk) disable iff (rst)
        rise |=> pend);
endmodule

// File: rtl/uart_irq_snapshot.sv
module uart_irq_snapshot
    import uart_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hold,
    input  ident_t live,
    output ident_t ident_q
);
    always_ff @(posedge clk) begin
        if (rst)
            ident_q <= IDENT_IDLE;
        else if (!hold)
            ident_q <= live;
    end

    assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        hold |=> ident_q == $past(ident_q));
    assert_legal_code_R6: assert property (@(posedge clk) disable iff (rst)
        (!ident_q.pend_n |-> id_is_legal(ident_q.id)) and (ident_q.pend_n |-> ident_q.id == ID_NONE));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fifo_en,
    input  logic              thr_write,
    input  logic              line_err,
    input  logic              rx_avail,
    input  logic              rx_timeout,
    input  logic              tx_empty,
    output logic              irq
);
    localparam logic ADDR_EN = 1'b0;
    localparam logic ADDR_ID = 1'b1;
    localparam int   PAD_W   = DATA_W - EN_W;

    logic [EN_W-1:0] en;
    logic            thre_pend;
    logic            thre_rise;
    logic            rd_ident;
    logic            rd_clear;
    irq_src_t        src;
    ident_t          live;
    ident_t          ident_q;

    assign rd_ident = bus_rd && (bus_addr == ADDR_ID);
    assign rd_clear = rd_ident && !ident_q.pend_n && (ident_q.id == ID_THRE);

    uart_irq_enable #(.DATA_W(DATA_W)) u_enable (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr && (bus_addr == ADDR_EN)),
        .wdata (bus_wdata),
        .en    (en)
    );

    uart_irq_thre u_thre (
        .clk       (clk),
        .rst       (rst),
        .tx_empty  (tx_empty),
        .thr_write (thr_write),
        .rd_clear  (rd_clear),
        .pend      (thre_pend),
        .rise      (thre_rise)
    );

    always_comb begin
        src.line_err = line_err;
        src.rx_avail = rx_avail;
        src.rx_tmo   = rx_timeout;
        src.tx_empty = thre_pend || thre_rise;
        live         = pick_ident(src, en);
    end

    uart_irq_snapshot u_snap (
        .clk     (clk),
        .rst     (rst),
        .hold    (rd_ident),
        .live    (live),
        .ident_q (ident_q)
    );

    assign irq = !ident_q.pend_n;

    always_comb begin
        if (bus_addr == ADDR_EN)
            bus_rdata = {{PAD_W{1'b0}}, en};
        else
            bus_rdata = {fifo_en, fifo_en, {(DATA_W-6){1'b0}}, ident_q};
    end

    assert_rls_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (!rd_ident && en[EN_LS] && line_err) |=> ident_q.id == ID_RLS);
    assert_rx_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (!rd_ident && !en[EN_RX] && !(en[EN_LS] && line_err)) |=> (ident_q.id != ID_RDA) && (ident_q.id != ID_CTI));
    assert_thre_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (!rd_ident && !en[EN_TX]) |=> ident_q.id != ID_THRE);
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       fifo_en = 1'b0, thr_write = 1'b0;
    logic       line_err = 1'b0, rx_avail = 1'b0, rx_timeout = 1'b0, tx_empty = 1'b0;
    logic       irq;

    int n_chk = 0, n_fail = 0;
    logic       m_thre = 1'b0;
    logic       prev_tx = 1'b0;
    logic [2:0] m_en = 3'b000;

    always #4 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_en(fifo_en),
        .thr_write(thr_write), .line_err(line_err), .rx_avail(rx_avail),
        .rx_timeout(rx_timeout), .tx_empty(tx_empty), .irq(irq)
    );

    function automatic logic [7:0] exp_ident(logic [2:0] en, logic le, logic ra, logic to,
                                             logic th, logic fe);
        logic [3:0] lo;
        if (en[2] && le)      lo = 4'b0110;
        else if (en[0] && ra) lo = 4'b0100;
        else if (en[0] && to) lo = 4'b1100;
        else if (en[1] && th) lo = 4'b0010;
        else                  lo = 4'b0001;
        return {fe, fe, 2'b00, lo};
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr_en(input logic [7:0] v);
        bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
        m_en = v[2:0];
    endtask

    task automatic pulse_thr();
        thr_write = 1'b1;
        @(negedge clk);
        thr_write = 1'b0;
        m_thre = 1'b0;
    endtask

    task automatic drive_src(input logic le, input logic ra, input logic to, input logic tx);
        line_err = le; rx_avail = ra; rx_timeout = to; tx_empty = tx;
        if (tx && !prev_tx) m_thre = 1'b1;
        prev_tx = tx;
    endtask

    task automatic check_ident(input string req);
        logic [7:0] e, d;
        e = exp_ident(m_en, line_err, rx_avail, rx_timeout, m_thre, fifo_en);
        chk({7'd0, irq}, {7'd0, ~e[0]}, "R8 irq");
        rd(1'b1, d);
        chk(d, e, req);
        if (e[3:0] == 4'b0010) m_thre = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1234));
        step(3);
        rst = 1'b0;
        step(1);
        // R1 R2 reset state
        rd(1'b0, d); chk(d, 8'h00, "R1 enable reset");
        chk({7'd0, irq}, 8'h00, "R2 irq reset");
        rd(1'b1, d); chk(d, 8'h01, "R2 ident reset");
        // R1 reserved bits dropped
        wr_en(8'hFF);
        rd(1'b0, d); chk(d, 8'h07, "R1 reserved bits");
        // R7 fifo mirror
        fifo_en = 1'b1; step(1);
        rd(1'b1, d); chk(d, 8'hC1, "R7 fifo mirror");
        fifo_en = 1'b0;
        // R3 R4 R5 R6: every source combination, all enabled
        for (int c = 0; c < 16; c++) begin
            pulse_thr();
            drive_src(1'b0, 1'b0, 1'b0, 1'b0);
            step(1);
            drive_src(c[3], c[2], c[1], c[0]);
            step(2);
            check_ident("R3/R4/R5/R6 priority combo");
        end
        // R4 shared enable bit 0 gates timeout too
        pulse_thr();
        wr_en(8'h06);
        drive_src(1'b0, 1'b1, 1'b1, 1'b0);
        step(2);
        check_ident("R4 rx gated");
        // R10 THRE cleared by read that reports it
        wr_en(8'h02);
        drive_src(1'b0, 1'b0, 1'b0, 1'b1);
        step(2);
        check_ident("R10 thre reported");
        step(2);
        check_ident("R10 thre cleared by read");
        // R9 event in read cycle appears only on next read
        pulse_thr();
        wr_en(8'h07);
        drive_src(1'b0, 1'b1, 1'b0, 1'b1);
        pulse_thr();
        step(2);
        bus_addr = 1'b1; bus_rd = 1'b1; line_err = 1'b1;
        #1 chk(bus_rdata, 8'h04, "R9 read in event cycle");
        @(negedge clk);
        bus_rd = 1'b0;
        #1 chk(bus_rdata, 8'h04, "R9 held across read edge");
        @(negedge clk);
        rd(1'b1, d); chk(d, 8'h06, "R9 next read sees event");
        // random mix
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(3) == 0) pulse_thr();
            if ($urandom_range(2) == 0) wr_en(8'($urandom));
            fifo_en = 1'($urandom);
            drive_src(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            step(2);
            check_ident("R3/R4/R5/R7/R10 random");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule